// File: doc/BRIEF.md
# Differential QPSK Baseband Modulator

This block turns a serial bit stream into a digital QPSK carrier. Bits arrive one per transfer on a valid/ready input and are paired into 2-bit symbols. Each symbol is not sent as an absolute phase: it is sent as a phase step added to the phase of the previous symbol. A receiver that locks its carrier with an unknown quarter-turn rotation still recovers the data, because it reads only the difference between consecutive phases. The current phase index picks one of four constellation points at π/4, 3π/4, 5π/4 or 7π/4. The signs of I and Q for that point are mixed onto a carrier with four samples per carrier cycle. The result is the registered signed sample I·cos − Q·sin.

A symbol lasts a fixed number of clock cycles (`SYM_CYC`, 8 by default; this gives two carrier cycles per symbol). If no complete bit pair is waiting when a symbol slot starts, the slot is sent as silence (zero samples) and the phase is kept. The block also carries the matching differential decoder as an independent path. It takes a stream of received phase indices and returns the dibits, so the modulator's own index output can be looped back with any fixed rotation.

Top module: `dqpsk_mod`

## Requirements
- R1: While `rst_n` is low, `smp_out` is 0, `sym_strobe` is 0, `sym_idx` is 0 (phase π/4), `bit_ready` is 1 and `dec_out_valid` is 0.
- R2: A bit is taken on a clock edge where `bit_valid` and `bit_ready` are both high. The first bit taken of a pair becomes bit 1 (MSB) of the dibit, and the second becomes bit 0. Once a full pair waits, `bit_ready` stays low until the pair is consumed at a symbol boundary.
- R3: Symbol boundaries fall on every edge m after reset release with m a multiple of `SYM_CYC` (8). A waiting pair is consumed only there. `sym_strobe` is high for exactly the one cycle after that edge, and `sym_idx` changes only in a strobe cycle.
- R4: On consumption, the new index is (old index + step) mod 4, where the dibit gives the step as 00→0, 01→1, 11→2, 10→3 (in quarter turns).
- R5: Index 0,1,2,3 stands for (I,Q) signs (+,+), (−,+), (−,−), (+,−).
- R6: In a symbol that carries data, the k-th cycle after the strobe cycle (k = 1..8) shows `smp_out` = A·I, −A·Q, −A·I, A·Q for (k−1) mod 4 = 0,1,2,3. Here A = `AMP` (100), and the value is always 0, +A or −A.
- R7: If no full pair waits at a boundary, that whole symbol outputs 0, `sym_strobe` stays low and `sym_idx` is held. A lone first bit stays pending until its partner arrives.
- R8: When `dec_in_valid` is high on an edge, the decoder shows `dec_out_valid` = 1 in the next cycle with `dec_out_dibit` = the 2-bit code of step (in − previous in) mod 4, using the R4 table. The previous index resets to 0. With `dec_in_valid` low, `dec_out_valid` is 0 in the next cycle.
- R9: If every index fed to the decoder is rotated by the same k in 0..3, the decoded dibits equal the sent dibits from the second symbol on. The first symbol decodes as the step code of (its step + k).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four samples per carrier cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Input bit present |
| bit_data | input | 1 | Input bit value |
| bit_ready | output | 1 | Block can take a bit this cycle |
| smp_out | output | SMP_W | Registered signed carrier sample |
| sym_strobe | output | 1 | One-cycle pulse when a new symbol index is loaded |
| sym_idx | output | 2 | Current encoded phase index |
| dec_in_valid | input | 1 | Received phase index present |
| dec_in_idx | input | 2 | Received phase index |
| dec_out_valid | output | 1 | Decoded dibit present |
| dec_out_dibit | output | 2 | Decoded dibit |

## Verification
On every cycle, the assertions check the following. Strobes happen only at symbol boundaries and never twice in a row. The phase index moves only with a strobe. Samples never leave the three legal levels. Idle slots give zero samples. The decoder answers every valid index one cycle later. Only the bench's scenarios can show the full data mapping: the phase arithmetic over all 16 consecutive dibit pairs, the exact sample sequence inside each symbol, back-pressure against a waiting pair, a pause with one lone bit pending, and loopback through the decoder under each of the four fixed rotations.

// File: rtl/dqpsk_pkg.sv
package dqpsk_pkg;

  typedef struct packed {
    logic i_neg;
    logic q_neg;
  } iq_sign_t;

  // dibit code -> phase step in quarter turns (00:0, 01:1, 11:2, 10:3)
  function automatic logic [1:0] code_to_step(input logic [1:0] code);
    return {code[1], code[1] ^ code[0]};
  endfunction

  // phase step -> dibit code
  function automatic logic [1:0] step_to_code(input logic [1:0] step);
    return {step[1], step[1] ^ step[0]};
  endfunction

  // phase index -> signs of I and Q
  function automatic iq_sign_t idx_to_sign(input logic [1:0] idx);
    iq_sign_t s;
    s.i_neg = idx[1] ^ idx[0];
    s.q_neg = idx[1];
    return s;
  endfunction

endpackage

// File: rtl/dqpsk_pair_collect.sv
module dqpsk_pair_collect (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       in_ready,
  input  logic       take,
  output logic       pair_full,
  output logic [1:0] pair
);
  logic       half_q, half_d;
  logic       first_q, first_d;
  logic       full_q, full_d;
  logic [1:0] pair_q, pair_d;
  logic       accept;

  assign in_ready  = !full_q;
  assign accept    = in_valid && in_ready;
  assign pair_full = full_q;
  assign pair      = pair_q;

  always_comb begin
    half_d  = half_q;
    first_d = first_q;
    full_d  = full_q;
    pair_d  = pair_q;
    if (take) full_d = 1'b0;
    if (accept) begin
      if (!half_q) begin
        half_d  = 1'b1;
        first_d = in_bit;
      end else begin
        half_d = 1'b0;
        pair_d = {first_q, in_bit};
        full_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      first_q <= 1'b0;
      full_q  <= 1'b0;
      pair_q  <= 2'b00;
    end else begin
      half_q  <= half_d;
      first_q <= first_d;
      full_q  <= full_d;
      pair_q  <= pair_d;
    end
  end
endmodule

// File: rtl/dqpsk_phase_enc.sv
module dqpsk_phase_enc
  import dqpsk_pkg::*;
#(
  parameter int SYM_CYC = 8,
  localparam int CNT_W  = $clog2(SYM_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_full,
  input  logic [1:0]       pair,
  output logic             take,
  output logic             active,
  output logic [1:0]       idx,
  output logic             strobe,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic [1:0]       idx_q, idx_d;
  logic             stb_q, stb_d;
  logic             boundary;

  assign boundary = (cnt_q == CNT_W'(SYM_CYC - 1));
  assign take     = boundary && pair_full;

  always_comb begin
    cnt_d = boundary ? '0 : cnt_q + CNT_W'(1);
    act_d = act_q;
    idx_d = idx_q;
    stb_d = 1'b0;
    if (boundary) begin
      act_d = pair_full;
      stb_d = pair_full;
      if (pair_full) idx_d = idx_q + code_to_step(pair);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      idx_q <= 2'd0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      idx_q <= idx_d;
      stb_q <= stb_d;
    end
  end

  assign active = act_q;
  assign idx    = idx_q;
  assign strobe = stb_q;
  assign cnt    = cnt_q;
endmodule

// File: rtl/dqpsk_iq_mixer.sv
module dqpsk_iq_mixer
  import dqpsk_pkg::*;
#(
  parameter int SMP_W = 8,
  parameter int AMP   = 100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    active,
  input  logic [1:0]              idx,
  input  logic [1:0]              phase,
  output logic signed [SMP_W-1:0] smp
);
  localparam logic signed [SMP_W-1:0] POS = SMP_W'(AMP);
  localparam logic signed [SMP_W-1:0] NEG = -POS;

  iq_sign_t                sgn;
  logic                    neg;
  logic signed [SMP_W-1:0] smp_q, smp_d;

  assign sgn = idx_to_sign(idx);

  // carrier points: cos 1,0,-1,0 and sin 0,1,0,-1; sample = I*cos - Q*sin
  always_comb begin
    unique case (phase)
      2'd0:    neg = sgn.i_neg;
      2'd1:    neg = !sgn.q_neg;
      2'd2:    neg = !sgn.i_neg;
      default: neg = sgn.q_neg;
    endcase
    if (!active) smp_d = '0;
    else         smp_d = neg ? NEG : POS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= smp_d;
  end

  assign smp = smp_q;
endmodule

// File: rtl/dqpsk_phase_dec.sv
module dqpsk_phase_dec
  import dqpsk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [1:0] in_idx,
  output logic       out_valid,
  output logic [1:0] out_dibit
);
  logic [1:0] prev_q, prev_d;
  logic       vld_q, vld_d;
  logic [1:0] dib_q, dib_d;

  always_comb begin
    prev_d = prev_q;
    dib_d  = dib_q;
    vld_d  = in_valid;
    if (in_valid) begin
      prev_d = in_idx;
      dib_d  = step_to_code(in_idx - prev_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 2'd0;
      vld_q  <= 1'b0;
      dib_q  <= 2'd0;
    end else begin
      prev_q <= prev_d;
      vld_q  <= vld_d;
      dib_q  <= dib_d;
    end
  end

  assign out_valid = vld_q;
  assign out_dibit = dib_q;
endmodule

// File: rtl/dqpsk_mod.sv
module dqpsk_mod #(
  parameter int SMP_W   = 8,
  parameter int AMP     = 100,
  parameter int SYM_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_data,
  output logic             bit_ready,
  output logic [SMP_W-1:0] smp_out,
  output logic             sym_strobe,
  output logic [1:0]       sym_idx,
  input  logic             dec_in_valid,
  input  logic [1:0]       dec_in_idx,
  output logic             dec_out_valid,
  output logic [1:0]       dec_out_dibit
);
  localparam int CNT_W = $clog2(SYM_CYC);

  initial begin
    if (SYM_CYC < 4 || (SYM_CYC % 4) != 0)
      $error("SYM_CYC must be a positive multiple of 4");
    if (AMP <= 0 || AMP >= (1 << (SMP_W - 1)))
      $error("AMP must fit the signed sample width");
  end

  logic             pair_full, take, sym_active;
  logic [1:0]       pair;
  logic [CNT_W-1:0] sym_cnt;
  logic signed [SMP_W-1:0] smp_s;

  dqpsk_pair_collect u_collect (
    .clk(clk), .rst_n(rst_n),
    .in_valid(bit_valid), .in_bit(bit_data), .in_ready(bit_ready),
    .take(take), .pair_full(pair_full), .pair(pair)
  );

  dqpsk_phase_enc #(.SYM_CYC(SYM_CYC)) u_enc (
    .clk(clk), .rst_n(rst_n),
    .pair_full(pair_full), .pair(pair), .take(take),
    .active(sym_active), .idx(sym_idx), .strobe(sym_strobe), .cnt(sym_cnt)
  );

  dqpsk_iq_mixer #(.SMP_W(SMP_W), .AMP(AMP)) u_mix (
    .clk(clk), .rst_n(rst_n),
    .active(sym_active), .idx(sym_idx), .phase(sym_cnt[1:0]), .smp(smp_s)
  );

  assign smp_out = smp_s;

  dqpsk_phase_dec u_dec (
    .clk(clk), .rst_n(rst_n),
    .in_valid(dec_in_valid), .in_idx(dec_in_idx),
    .out_valid(dec_out_valid), .out_dibit(dec_out_dibit)
  );
endmodule

// File: rtl/dqpsk_mod_chk.sv
module dqpsk_mod_chk #(
  parameter int SMP_W = 8,
  parameter int AMP   = 100,
  parameter int CNT_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sym_strobe,
  input logic [1:0]              sym_idx,
  input logic                    sym_active,
  input logic [CNT_W-1:0]        sym_cnt,
  input logic signed [SMP_W-1:0] smp_out,
  input logic                    dec_in_valid,
  input logic                    dec_out_valid
);
  localparam logic signed [SMP_W-1:0] POS = SMP_W'(AMP);
  localparam logic signed [SMP_W-1:0] NEG = -POS;

  AST_STROBE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    sym_strobe |-> (sym_cnt == '0)); // R3
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_strobe |=> !sym_strobe); // R3
  AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_strobe |-> $stable(sym_idx)); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_active |=> (smp_out == '0)); // R7
  AST_SAMPLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_out == '0) || (smp_out == POS) || (smp_out == NEG)); // R6
  AST_DEC_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    dec_in_valid |=> dec_out_valid); // R8
  AST_DEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_in_valid |=> !dec_out_valid); // R8
endmodule

bind dqpsk_mod dqpsk_mod_chk #(.SMP_W(SMP_W), .AMP(AMP), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_strobe(sym_strobe), .sym_idx(sym_idx),
  .sym_active(sym_active), .sym_cnt(sym_cnt), .smp_out(smp_s),
  .dec_in_valid(dec_in_valid), .dec_out_valid(dec_out_valid)
);

// File: tb/sim_dqpsk_mod.sv
module sim_dqpsk_mod;
  localparam int CLK_PERIOD = 10;
  localparam int SMP_W = 8;
  localparam int AMP   = 100;
  localparam int NSYM  = 32;
  localparam int NBIT  = 2 * NSYM;

  logic clk, rst_n, bit_valid, bit_data;
  logic bit_ready, sym_strobe, dec_out_valid;
  logic [SMP_W-1:0] smp_out;
  logic [1:0] sym_idx, dec_out_dibit, rot, dec_in_idx;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  int dib[NSYM];
  bit bits[NBIT];

  assign dec_in_idx = sym_idx + rot;

  dqpsk_mod #(.SMP_W(SMP_W), .AMP(AMP), .SYM_CYC(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .smp_out(smp_out), .sym_strobe(sym_strobe),
    .sym_idx(sym_idx), .dec_in_valid(sym_strobe), .dec_in_idx(dec_in_idx),
    .dec_out_valid(dec_out_valid), .dec_out_dibit(dec_out_dibit)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not end (actual %0d cycles, expected < 100000)", cyc);
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, exp, $time);
    end
  endtask

  // R4 table: code 00->0, 01->1, 11->2, 10->3
  function automatic int step_of(input int code);
    case (code)
      0: return 0; 1: return 1; 3: return 2; default: return 3;
    endcase
  endfunction
  function automatic int code_of(input int step);
    case (step)
      0: return 0; 1: return 1; 2: return 3; default: return 2;
    endcase
  endfunction

  // R5/R6: expected sample from index and carrier point
  function automatic int exp_smp(input int idx, input int ph);
    int iv, qv;
    iv = (idx == 1 || idx == 2) ? -1 : 1;
    qv = (idx >= 2) ? -1 : 1;
    case (ph)
      0: return AMP * iv;
      1: return -AMP * qv;
      2: return -AMP * iv;
      default: return AMP * qv;
    endcase
  endfunction

  task automatic run_pass(input int k);
    int m = 0, bi = 0, sym_n = 0, midx = 0, act = 0, act_p = 0, idx_p = 0;
    int pause = 0, tail = 0, dec_exp = 0, pend;
    bit dec_pend = 0;
    for (int j = 0; j < NSYM; j++) begin
      dib[j] = (((j / 2) % 2 == 0) ? ((j / 8) % 4) : ((j / 2) % 4)) ^ k;
      bits[2 * j]     = dib[j][1];
      bits[2 * j + 1] = dib[j][0];
    end
    rot = 2'(k);
    bit_valid = 1'b0; bit_data = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 smp_out", int'($signed(smp_out)), 0);
    check("R1 sym_strobe", int'(sym_strobe), 0);
    check("R1 sym_idx", int'(sym_idx), 0);
    check("R1 bit_ready", int'(bit_ready), 1);
    check("R1 dec_out_valid", int'(dec_out_valid), 0);
    rst_n = 1'b1;
    while (tail < 20) begin
      @(negedge clk);
      m++;
      if (bit_valid) bi++;
      // R6 sample formed from state after previous edge
      check("R6 sample", int'($signed(smp_out)), act_p ? exp_smp(idx_p, (m - 1) % 4) : 0);
      if (dec_pend) begin
        check("R8 dec_out_valid", int'(dec_out_valid), 1);
        check(sym_n == 1 ? "R9 first decoded" : "R9 decoded", int'(dec_out_dibit), dec_exp);
        dec_pend = 0;
      end else check("R8 dec idle", int'(dec_out_valid), 0);
      if (sym_strobe) begin
        check("R3 strobe on boundary", m % 8, 0);
        midx = (midx + step_of(dib[sym_n])) % 4;
        check("R4 sym_idx", int'(sym_idx), midx);
        dec_exp = (sym_n == 0) ? code_of((step_of(dib[0]) + k) % 4) : dib[sym_n];
        dec_pend = 1;
        act = 1;
        sym_n++;
      end else begin
        if (m % 8 == 0) act = 0;
        check("R7 sym_idx held", int'(sym_idx), midx);
      end
      pend = bi - 2 * sym_n;
      check("R2 bit_ready", int'(bit_ready), (pend < 2) ? 1 : 0);
      act_p = act; idx_p = midx;
      if (k == 2 && bi == 21 && pause < 30) begin
        pause++;
        bit_valid = 1'b0;
      end else if (bi < NBIT && bit_ready) begin
        bit_valid = 1'b1;
        bit_data  = bits[bi];
      end else bit_valid = 1'b0;
      if (sym_n == NSYM) tail++;
      if (m > 3000) break;
    end
    check("R3 symbol count", sym_n, NSYM);
  endtask

  initial begin
    rot = 2'd0; rst_n = 1'b0; bit_valid = 1'b0; bit_data = 1'b0;
    for (int k = 0; k < 4; k++) run_pass(k);
    done = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule